// File: doc/BRIEF.md
# Two-Table Trace Dead-Block Predictor

This block guesses, at every fill and every hit, whether the touched cache block has just seen its final use before eviction. For each block it holds a trace signature: a running sum, kept to 16 bits, of the program counters of the memory instructions that accessed the block since it was last filled. The signature selects one counter in each of two tables of 2-bit saturating confidence counters. The two tables use different hashes of the signature, so two signatures that collide in one table are unlikely to collide in the other. The block is called dead when the two counters together reach a threshold.

Training is driven by the access stream. A hit shows that the block's previous signature was not a last touch, so the counters for that signature move toward live. An eviction shows that the final signature was a last touch, so its counters move toward dead. Each block slot has a two-state machine. The states are IDLE (not tracked) and TRACKED. The transitions are FILL (IDLE or TRACKED to TRACKED, signature reloaded), HIT (TRACKED to TRACKED, signature extended) and EVICT (TRACKED to IDLE). Tag storage, replacement and data movement belong to the surrounding cache.

Top module: `deadblk_pred`

## Requirements
- R1: A fill (acc_kind 2'b00) loads the block's signature with acc_pc[15:0], marks the block tracked and issues a prediction computed from that signature.
- R2: A hit (acc_kind 2'b01) on a tracked block replaces the signature with (signature + acc_pc[15:0]) mod 2^16 and issues a prediction computed from the new signature.
- R3: Table A is indexed by signature[7:0] and table B by signature[15:8] XOR signature[7:0].
- R4: The prediction is dead exactly when counter A plus counter B is at least 4; each counter spans 0..3.
- R5: An eviction (acc_kind 2'b10) of a tracked block raises both counters selected by its current signature by one, saturating at 3, returns the block to untracked and issues no prediction.
- R6: A hit on a tracked block lowers both counters selected by its previous signature by one, saturating at 0.
- R7: When a hit's new signature selects the same entry that the hit is training, the prediction uses the value after training.
- R8: pred_valid is 1 in the cycle after a fill or a tracked-block hit and 0 otherwise; in that cycle pred_blk equals the accessed block number.
- R9: With acc_valid low, with acc_kind 2'b11, or with a hit or eviction of an untracked block, no counter or signature changes and pred_valid is 0 in the next cycle.
- R10: Reset clears every counter to 0, makes every block untracked and holds pred_valid and pred_dead at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access event is presented this cycle |
| acc_kind | input | 2 | 00 fill, 01 hit, 10 evict, 11 reserved |
| acc_blk | input | BLK_W (4) | Block slot number |
| acc_pc | input | PC_W (32) | PC of the accessing instruction |
| pred_valid | output | 1 | A prediction is presented |
| pred_dead | output | 1 | 1 predicts dead, 0 predicts live |
| pred_blk | output | BLK_W (4) | Block the prediction refers to |

## Verification
The stimulus table runs the same signature through repeated fill and evict pairs. This walks one counter pair up through the threshold and into saturation. Repeated hits with a zero PC then walk the pair back down to 0, keep the index fixed and expose any missing forwarding. A second block uses a signature that matches the first in its low byte but not in its upper byte, which shows whether table B really folds the two halves. Carry-out PC sums, hits and evictions of untracked blocks, the reserved code, idle cycles and a reset in mid-run each separate a correct signature or state update from a wrong one.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    typedef enum logic [1:0] {
        ACC_FILL  = 2'b00,
        ACC_HIT   = 2'b01,
        ACC_EVICT = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic {
        BLK_IDLE    = 1'b0,
        BLK_TRACKED = 1'b1
    } blk_state_e;

endpackage

// File: rtl/dbp_sig_store.sv
module dbp_sig_store
    import dbp_pkg::*;
#(
    parameter int NBLK  = 16,
    parameter int BLK_W = 4,
    parameter int SIG_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  acc_kind_e        kind_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic             tracked_o,
    output logic [SIG_W-1:0] old_sig_o,
    output logic [SIG_W-1:0] new_sig_o
);

    logic [SIG_W-1:0] pc_part;
    logic [SIG_W-1:0] sig_all [NBLK];
    blk_state_e       st_all  [NBLK];

    assign pc_part = pc_i[SIG_W-1:0];

    // one state machine and one signature register per block slot
    for (genvar g = 0; g < NBLK; g++) begin : g_slot
        blk_state_e       st_q, st_d;
        logic [SIG_W-1:0] sig_q, sig_d;
        logic             sel;

        assign sel = valid_i && (blk_i == BLK_W'(g));

        always_comb begin
            st_d  = st_q;
            sig_d = sig_q;
            unique case (st_q)
                BLK_IDLE: begin
                    if (sel && kind_i == ACC_FILL) begin
                        st_d  = BLK_TRACKED;
                        sig_d = pc_part;
                    end
                end
                BLK_TRACKED: begin
                    if (sel) begin
                        unique case (kind_i)
                            ACC_FILL:  sig_d = pc_part;
                            ACC_HIT:   sig_d = sig_q + pc_part;
                            ACC_EVICT: st_d  = BLK_IDLE;
                            ACC_RSVD:  st_d  = st_q;
                        endcase
                    end
                end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q  <= BLK_IDLE;
                sig_q <= '0;
            end else begin
                st_q  <= st_d;
                sig_q <= sig_d;
            end
        end

        assign sig_all[g] = sig_q;
        assign st_all[g]  = st_q;
    end

    assign tracked_o = (st_all[blk_i] == BLK_TRACKED);
    assign old_sig_o = sig_all[blk_i];

    always_comb begin
        if (kind_i == ACC_FILL) new_sig_o = pc_part;
        else                    new_sig_o = sig_all[blk_i] + pc_part;
    end

endmodule

// File: rtl/dbp_conf_table.sv
module dbp_conf_table #(
    parameter int DEPTH = 256,
    parameter int CNT_W = 2,
    parameter int SIG_W = 16,
    parameter int HASH  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] rd_sig_i,
    input  logic             trn_en_i,
    input  logic             trn_up_i,
    input  logic [SIG_W-1:0] trn_sig_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int HALF  = SIG_W / 2;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [IDX_W-1:0] rd_idx, trn_idx;
    logic [CNT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cur, nxt;

    if (HASH == 0) begin : g_low
        assign rd_idx  = rd_sig_i[IDX_W-1:0];
        assign trn_idx = trn_sig_i[IDX_W-1:0];
    end else begin : g_fold
        logic [HALF-1:0] rd_f, trn_f;
        assign rd_f    = rd_sig_i[SIG_W-1:HALF] ^ rd_sig_i[HALF-1:0];
        assign trn_f   = trn_sig_i[SIG_W-1:HALF] ^ trn_sig_i[HALF-1:0];
        assign rd_idx  = rd_f[IDX_W-1:0];
        assign trn_idx = trn_f[IDX_W-1:0];
    end

    assign cur = mem[trn_idx];

    always_comb begin
        if (trn_up_i) nxt = (cur == CMAX) ? cur : cur + 1'b1;
        else          nxt = (cur == '0)   ? cur : cur - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (trn_en_i) begin
            mem[trn_idx] <= nxt;
        end
    end

    // same-entry read during training sees the trained value
    assign cnt_o = (trn_en_i && rd_idx == trn_idx) ? nxt : mem[rd_idx];

endmodule

// File: rtl/deadblk_pred.sv
module deadblk_pred
    import dbp_pkg::*;
#(
    parameter int NBLK      = 16,
    parameter int PC_W      = 32,
    parameter int SIG_W     = 16,
    parameter int TBL_DEPTH = 256,
    parameter int CNT_W     = 2,
    parameter int THRESH    = 4,
    localparam int BLK_W    = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [1:0]       acc_kind,
    input  logic [BLK_W-1:0] acc_blk,
    input  logic [PC_W-1:0]  acc_pc,
    output logic             pred_valid,
    output logic             pred_dead,
    output logic [BLK_W-1:0] pred_blk
);

    localparam int NTBL  = 2;
    localparam int SUM_W = CNT_W + 1;

    acc_kind_e        kind;
    logic             tracked;
    logic [SIG_W-1:0] old_sig, new_sig;
    logic             do_pred, do_train, train_up;
    logic [CNT_W-1:0] cnt [NTBL];
    logic [SUM_W-1:0] sum;

    assign kind = acc_kind_e'(acc_kind);

    dbp_sig_store #(
        .NBLK (NBLK),
        .BLK_W(BLK_W),
        .SIG_W(SIG_W),
        .PC_W (PC_W)
    ) sig_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (acc_valid),
        .kind_i   (kind),
        .blk_i    (acc_blk),
        .pc_i     (acc_pc),
        .tracked_o(tracked),
        .old_sig_o(old_sig),
        .new_sig_o(new_sig)
    );

    always_comb begin
        do_pred  = 1'b0;
        do_train = 1'b0;
        train_up = 1'b0;
        if (acc_valid) begin
            unique case (kind)
                ACC_FILL:  do_pred = 1'b1;
                ACC_HIT: begin
                    do_pred  = tracked;
                    do_train = tracked;
                end
                ACC_EVICT: begin
                    do_train = tracked;
                    train_up = 1'b1;
                end
                ACC_RSVD:  do_pred = 1'b0;
            endcase
        end
    end

    // table t uses hash variant t
    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        dbp_conf_table #(
            .DEPTH(TBL_DEPTH),
            .CNT_W(CNT_W),
            .SIG_W(SIG_W),
            .HASH (t)
        ) tbl_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_sig_i (new_sig),
            .trn_en_i (do_train),
            .trn_up_i (train_up),
            .trn_sig_i(old_sig),
            .cnt_o    (cnt[t])
        );
    end

    assign sum = SUM_W'(cnt[0]) + SUM_W'(cnt[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_dead  <= 1'b0;
            pred_blk   <= '0;
        end else begin
            pred_valid <= do_pred;
            pred_dead  <= do_pred && (int'(sum) >= THRESH);
            pred_blk   <= acc_blk;
        end
    end

endmodule

// File: rtl/deadblk_pred_chk.sv
module deadblk_pred_chk #(
    parameter int BLK_W = 4,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [1:0]       acc_kind,
    input logic [BLK_W-1:0] acc_blk,
    input logic             pred_valid,
    input logic             pred_dead,
    input logic [BLK_W-1:0] pred_blk
);

    // R1 / R8: a fill always yields a prediction next cycle
    a_r1_fill_predicts: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b00) |=> pred_valid);

    // R8: the prediction names the accessed block
    a_r8_blk_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b00) |=> (pred_blk == $past(acc_blk)));

    // R5: evictions never produce a prediction
    a_r5_evict_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b10) |=> !pred_valid);

    // R9: idle cycles and the reserved code produce nothing
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || acc_kind == 2'b11) |=> !pred_valid);

    // R4: a dead verdict only accompanies a valid prediction
    a_r4_dead_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pred_dead |-> pred_valid);

    // R10: outputs quiet while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!pred_valid && !pred_dead);
        end
    end

endmodule

bind deadblk_pred deadblk_pred_chk #(.BLK_W(BLK_W), .PC_W(PC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_kind  (acc_kind),
    .acc_blk   (acc_blk),
    .pred_valid(pred_valid),
    .pred_dead (pred_dead),
    .pred_blk  (pred_blk)
);

// File: tb/deadblk_pred_tb_top.sv
module deadblk_pred_tb_top;

    localparam logic [1:0] KF = 2'b00, KH = 2'b01, KE = 2'b10, KR = 2'b11;

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  blk;
        logic [31:0] pc;
        logic        ev;
        logic        ed;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{KF, 4'd1, 32'h0000_0010, 1'b1, 1'b0, 8'd1},  // R1 sum 0
        '{KE, 4'd1, 32'h0,         1'b0, 1'b0, 8'd5},  // R5 -> 1,1
        '{KF, 4'd1, 32'h0000_0010, 1'b1, 1'b0, 8'd4},  // R4 sum 2
        '{KE, 4'd1, 32'h0,         1'b0, 1'b0, 8'd5},  // -> 2,2
        '{KF, 4'd1, 32'h0000_0010, 1'b1, 1'b1, 8'd4},  // R4 sum 4 boundary
        '{KE, 4'd1, 32'h0,         1'b0, 1'b0, 8'd5},  // -> 3,3
        '{KE, 4'd1, 32'h0,         1'b0, 1'b0, 8'd9},  // R9 untracked evict
        '{KF, 4'd1, 32'h0000_0010, 1'b1, 1'b1, 8'd4},  // sum 6
        '{KE, 4'd1, 32'h0,         1'b0, 1'b0, 8'd5},  // R5 saturate at 3
        '{KF, 4'd1, 32'h0000_0010, 1'b1, 1'b1, 8'd5},  // still 6
        '{KH, 4'd1, 32'h0,         1'b1, 1'b1, 8'd7},  // R6 -> 2,2 sum 4
        '{KH, 4'd1, 32'h0,         1'b1, 1'b0, 8'd7},  // R7 -> 1,1 sum 2
        '{KH, 4'd1, 32'h0,         1'b1, 1'b0, 8'd6},  // -> 0,0
        '{KH, 4'd1, 32'h0,         1'b1, 1'b0, 8'd6},  // R6 saturate at 0
        '{KE, 4'd1, 32'h0,         1'b0, 1'b0, 8'd5},  // -> 1,1 untracked
        '{KH, 4'd1, 32'h0,         1'b0, 1'b0, 8'd9},  // R9 untracked hit
        '{KF, 4'd2, 32'h0000_0310, 1'b1, 1'b0, 8'd3},  // R3 A[10]1 B[13]0
        '{KE, 4'd2, 32'h0,         1'b0, 1'b0, 8'd5},  // A[10]2 B[13]1
        '{KF, 4'd2, 32'h0000_0310, 1'b1, 1'b0, 8'd3},  // sum 3
        '{KE, 4'd2, 32'h0,         1'b0, 1'b0, 8'd5},  // A[10]3 B[13]2
        '{KF, 4'd2, 32'h0000_0310, 1'b1, 1'b1, 8'd3},  // sum 5
        '{KF, 4'd3, 32'h0000_0510, 1'b1, 1'b0, 8'd3},  // R3 A[10]3 B[15]0
        '{KH, 4'd3, 32'h0000_0001, 1'b1, 1'b0, 8'd2},  // R2 sig 0511
        '{KH, 4'd3, 32'h0000_FAEF, 1'b1, 1'b0, 8'd2},  // R2 wraps to 0000
        '{KE, 4'd3, 32'h0,         1'b0, 1'b0, 8'd5},  // A[0]1 B[0]1
        '{KF, 4'd3, 32'h0000_0000, 1'b1, 1'b0, 8'd1},  // sum 2
        '{KE, 4'd3, 32'h0,         1'b0, 1'b0, 8'd5},  // A[0]2 B[0]2
        '{KF, 4'd4, 32'h0001_0000, 1'b1, 1'b1, 8'd1},  // R1 truncation, sum 4
        '{KH, 4'd4, 32'h0000_FFFF, 1'b1, 1'b0, 8'd2},  // sig FFFF, A[FF]0 B[0]1
        '{KH, 4'd2, 32'h0,         1'b1, 1'b0, 8'd7}   // R7 both forwarded, sum 2
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic [1:0]  acc_kind;
    logic [3:0]  acc_blk;
    logic [31:0] acc_pc;
    logic        pred_valid, pred_dead;
    logic [3:0]  pred_blk;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    deadblk_pred dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_blk(acc_blk), .acc_pc(acc_pc),
        .pred_valid(pred_valid), .pred_dead(pred_dead), .pred_blk(pred_blk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic v, input logic [1:0] k, input logic [3:0] b, input logic [31:0] p);
        acc_valid = v;
        acc_kind  = k;
        acc_blk   = b;
        acc_pc    = p;
        @(negedge clk);
    endtask

    task automatic expect_pred(input string req, input logic ev, input logic ed, input logic [3:0] eb);
        chk({req, " valid"}, pred_valid, ev);
        if (ev) begin
            chk({req, " dead"}, pred_dead, ed);
            chk({req, " blk"}, pred_blk, eb);
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        acc_valid = 1'b0; acc_kind = 2'b00; acc_blk = '0; acc_pc = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset valid", pred_valid, 1'b0);
        chk("R10 reset dead", pred_dead, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VECS[i].kind, VECS[i].blk, VECS[i].pc);
            expect_pred($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].ev, VECS[i].ed, VECS[i].blk);
        end

        // R9 idle cycle with fill code
        step(1'b0, KF, 4'd2, 32'h0);
        expect_pred("R9 idle", 1'b0, 1'b0, 4'd0);
        // R9 reserved code on tracked block 2 (A[10]1 B[13]1, sig 0310)
        step(1'b1, KR, 4'd2, 32'h0000_0100);
        expect_pred("R9 reserved", 1'b0, 1'b0, 4'd0);
        // block 2 still tracked with sig 0310: hit with 0 -> 0,0 sum 0
        step(1'b1, KH, 4'd2, 32'h0);
        expect_pred("R9 reserved left sig", 1'b1, 1'b0, 4'd2);

        // drive entry 77 to dead on block 5, then reset
        step(1'b1, KF, 4'd5, 32'h0000_0077);
        step(1'b1, KE, 4'd5, 32'h0);
        step(1'b1, KF, 4'd5, 32'h0000_0077);
        step(1'b1, KE, 4'd5, 32'h0);
        step(1'b1, KF, 4'd5, 32'h0000_0077);
        expect_pred("R4 pre-reset", 1'b1, 1'b1, 4'd5);
        acc_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 mid reset valid", pred_valid, 1'b0);
        chk("R10 mid reset dead", pred_dead, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 block 5 untracked after reset
        step(1'b1, KH, 4'd5, 32'h0);
        expect_pred("R10 untracked", 1'b0, 1'b0, 4'd0);
        // R10 counters cleared
        step(1'b1, KF, 4'd5, 32'h0000_0077);
        expect_pred("R10 cleared", 1'b1, 1'b0, 4'd5);
        step(1'b0, KF, 4'd0, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule